// File: doc/BRIEF.md
# Iterative Radix-2 FFT Core

This block computes a forward complex discrete Fourier transform of either 32 or 1024 points. It uses a single butterfly unit that works through every butterfly of every decimation-in-time stage in turn. The data stays in one dual-port working memory and is updated in place. A frame of signed 16-bit I/Q samples is streamed in while the core is idle. A start pulse then launches the stages. When the last stage is done, the spectrum streams out in natural bin order, with a valid flag on every sample and a last flag on the final one.

Incoming samples are written at bit-reversed addresses, so no reordering pass is needed at the output. Twiddle factors come from a table that holds a quarter period of a sine. The table is folded by index and sign to cover the half circle that the transform uses. Every butterfly halves its outputs with round-to-nearest and saturates them to 16 bits, so the result is the DFT scaled by 1/N.

Control is a four-state machine:
- ST_IDLE loads samples and waits.
- ST_RUN steps each butterfly through the phases PH_RD (read), PH_MUL (multiply) and PH_WR (write back).
- ST_OUT issues the output reads.
- ST_TAIL presents the final sample.

Its transitions are:
- "start accepted": ST_IDLE to ST_RUN.
- "final butterfly written": ST_RUN to ST_OUT, at PH_WR of the last butterfly of the last stage.
- "last address issued": ST_OUT to ST_TAIL.
- "frame sent": ST_TAIL to ST_IDLE.

Top module: `fft_iter_core`

## Requirements
- R1: `size_sel`=1 selects N=1024 and `size_sel`=0 selects N=32. The size used for loading and for the whole transform is the one present at the start pulse. The output frame is exactly N consecutive cycles with `out_valid` high, and `out_last` is high only on the N-th of them. `out_valid` is low in the cycle after `out_last`.
- R2: Output sample k (k = 0..N-1, in natural order) equals (1/N)·Σ x[n]·e^(−j2πkn/N) within ±5 LSB on each of `out_re` and `out_im` (signed 16-bit), for inputs with magnitude up to 16000 per component.
- R3: While idle, each cycle with `in_valid` high stores the next sample, giving x[0], x[1], … in arrival order. A sample with `in_last` high is the final one, and the sample after it is x[0] again.
- R4: `out_valid` first goes high at rising edge number 3·(N/2)·log2(N)+2, counting the edge that samples `start` as edge 1.
- R5: `busy` is high from the cycle after an accepted start through the cycle that carries `out_last`, and low in the cycle after.
- R6: A `start` pulse while `busy` is high is ignored: the run in progress is unchanged and no second frame follows.
- R7: `in_valid` samples presented while `busy` is high are ignored and do not alter the result being computed.
- R8: During and right after reset, `busy`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 1 | 1: 1024 points, 0: 32 points |
| in_valid | input | 1 | Input sample strobe |
| in_last | input | 1 | Marks the final input sample of a frame |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| start | input | 1 | Single-cycle pulse that starts the transform |
| busy | output | 1 | Transform or output in progress |
| out_valid | output | 1 | Output sample strobe |
| out_last | output | 1 | Marks the final output bin |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |

## Verification
The in-RTL assertions check the following on every cycle:
- the output handshake: last implies valid, valid implies busy, and the frame ends right after last;
- that busy only rises after a start;
- that the latched transform size cannot change in the middle of a run;
- that during a run the two memory ports never write the same word;
- that no input write slips in outside a butterfly write pair.

Only the bench scenarios can show the rest: numerical correctness against an arithmetic DFT for impulse, DC, tone and broadband inputs at both sizes, the exact start-to-output latency, and that the loading counter restarts after a short frame. They also show that a stray start pulse or input sample during a run leaves the spectrum untouched.

// File: rtl/fft_pkg.sv
package fft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_OUT,
        ST_TAIL
    } fft_state_e;

    typedef enum logic [1:0] {
        PH_RD,
        PH_MUL,
        PH_WR
    } fft_phase_e;

endpackage

// File: rtl/fft_dpram.sv
// Synchronous dual-port working store; clock-only process, registered reads
module fft_dpram #(
    parameter int WIDTH = 32,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic [AW-1:0]    a_addr,
    input  logic             a_we,
    input  logic [WIDTH-1:0] a_wd,
    output logic [WIDTH-1:0] a_rd,
    input  logic [AW-1:0]    b_addr,
    input  logic             b_we,
    input  logic [WIDTH-1:0] b_wd,
    output logic [WIDTH-1:0] b_rd
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wd;
        if (b_we) mem[b_addr] <= b_wd;
        a_rd <= mem[a_addr];
        b_rd <= mem[b_addr];
    end
endmodule

// File: rtl/fft_twiddle.sv
// Twiddle source: quarter-period sine table folded across the half circle.
// k indexes angle 2*pi*k/2^(KW+1); outputs cos and sin one cycle later.
module fft_twiddle #(
    parameter int KW   = 9,
    parameter int TW_W = 16
) (
    input  logic                   clk,
    input  logic [KW-1:0]          k,
    output logic signed [TW_W-1:0] cos_o,
    output logic signed [TW_W-1:0] sin_o
);
    localparam int  QN  = 1 << (KW - 1);
    localparam real AMP = real'((1 << (TW_W - 1)) - 1);
    localparam real HPI = 1.5707963267948966;

    logic signed [TW_W-1:0] qrom [QN+1];

    initial begin
        for (int i = 0; i <= QN; i++) begin
            qrom[i] = TW_W'($rtoi($floor(AMP * $sin(HPI * real'(i) / real'(QN)) + 0.5)));
        end
    end

    logic          upper;
    logic [KW-1:0] kk, c_idx, s_idx;

    always_comb begin
        upper = k[KW-1];
        kk    = {1'b0, k[KW-2:0]};
        if (upper) begin
            c_idx = kk;
            s_idx = KW'(QN) - kk;
        end else begin
            c_idx = KW'(QN) - kk;
            s_idx = kk;
        end
    end

    logic signed [TW_W-1:0] c_q, s_q;
    logic                   neg_q;

    always_ff @(posedge clk) begin
        c_q   <= qrom[c_idx];
        s_q   <= qrom[s_idx];
        neg_q <= upper;
    end

    assign cos_o = neg_q ? -c_q : c_q;
    assign sin_o = s_q;
endmodule

// File: rtl/fft_bfly.sv
// Radix-2 DIT butterfly: products registered on en, sums halved, rounded, saturated
module fft_bfly #(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_c,
    input  logic signed [TW-1:0] w_s,
    output logic signed [DW-1:0] ya_re,
    output logic signed [DW-1:0] ya_im,
    output logic signed [DW-1:0] yb_re,
    output logic signed [DW-1:0] yb_im
);
    localparam int MW = DW + TW;
    localparam int PW = MW + 1;
    localparam int EW = DW + 3;
    localparam logic signed [PW-1:0] P_HALF = PW'(1) << (TW - 2);
    localparam logic signed [EW-1:0] E_ONE  = EW'(1);
    localparam logic signed [EW-1:0] E_MAX  = EW'((1 << (DW - 1)) - 1);
    localparam logic signed [EW-1:0] E_MIN  = -E_MAX - E_ONE;

    logic signed [MW-1:0] m_rc, m_is, m_ic, m_rs;
    logic signed [PW-1:0] pr_q, pi_q;
    logic signed [DW-1:0] ar_q, ai_q;

    assign m_rc = b_re * w_c;
    assign m_is = b_im * w_s;
    assign m_ic = b_im * w_c;
    assign m_rs = b_re * w_s;

    always_ff @(posedge clk) begin
        if (en) begin
            pr_q <= PW'(m_rc) + PW'(m_is);
            pi_q <= PW'(m_ic) - PW'(m_rs);
            ar_q <= a_re;
            ai_q <= a_im;
        end
    end

    function automatic logic signed [DW-1:0] clip(input logic signed [EW-1:0] v);
        if (v > E_MAX)      return E_MAX[DW-1:0];
        else if (v < E_MIN) return E_MIN[DW-1:0];
        else                return v[DW-1:0];
    endfunction

    logic signed [EW-1:0] tr, ti, ar_e, ai_e;
    logic signed [EW-1:0] su_re, su_im, df_re, df_im;

    always_comb begin
        tr    = EW'((pr_q + P_HALF) >>> (TW - 1));
        ti    = EW'((pi_q + P_HALF) >>> (TW - 1));
        ar_e  = EW'(ar_q);
        ai_e  = EW'(ai_q);
        su_re = (ar_e + tr + E_ONE) >>> 1;
        su_im = (ai_e + ti + E_ONE) >>> 1;
        df_re = (ar_e - tr + E_ONE) >>> 1;
        df_im = (ai_e - ti + E_ONE) >>> 1;
        ya_re = clip(su_re);
        ya_im = clip(su_im);
        yb_re = clip(df_re);
        yb_im = clip(df_im);
    end
endmodule

// File: rtl/fft_iter_core.sv
module fft_iter_core
    import fft_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int TW_W      = 16,
    parameter int MAX_LOG   = 10,
    parameter int SMALL_LOG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              size_sel,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    input  logic              start,
    output logic              busy,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_re,
    output logic [DATA_W-1:0] out_im
);
    localparam int AW = MAX_LOG;
    localparam int KW = MAX_LOG - 1;
    localparam int SW = $clog2(MAX_LOG + 1);
    localparam int MW = 2 * DATA_W;

    fft_state_e state, state_nxt;
    fft_phase_e ph;

    logic [SW-1:0] log_q, load_log, stg, sh;
    logic [AW-1:0] in_cnt, ocnt, bix;
    logic [AW-1:0] ld_nm1, cur_nm1, last_b, ld_addr;
    logic [AW-1:0] half, j, grp, top, bot;
    logic [KW-1:0] tw_k;

    function automatic logic [AW-1:0] bit_rev(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    // size-derived limits
    always_comb begin
        load_log = size_sel ? SW'(MAX_LOG) : SW'(SMALL_LOG);
        ld_nm1   = AW'(((AW+1)'(1) << load_log) - (AW+1)'(1));
        cur_nm1  = AW'(((AW+1)'(1) << log_q) - (AW+1)'(1));
        last_b   = AW'((((AW+1)'(1) << log_q) >> 1) - (AW+1)'(1));
        ld_addr  = bit_rev(in_cnt) >> (SW'(MAX_LOG) - load_log);
    end

    // butterfly addressing: span 2^stg, twiddle step 2^(MAX_LOG-1-stg)
    always_comb begin
        half = AW'(1) << stg;
        j    = bix & (half - AW'(1));
        grp  = bix >> stg;
        top  = (grp << (stg + SW'(1))) | j;
        bot  = top | half;
        sh   = SW'(MAX_LOG - 1) - stg;
        tw_k = KW'(j << sh);
    end

    // memory and datapath hookup
    logic [MW-1:0] a_rd, b_rd, a_wd, b_wd;
    logic [AW-1:0] a_addr;
    logic          a_we, b_we, bf_en;
    logic signed [TW_W-1:0]   w_c, w_s;
    logic signed [DATA_W-1:0] ya_re, ya_im, yb_re, yb_im;

    always_comb begin
        b_we  = (state == ST_RUN) && (ph == PH_WR);
        a_we  = ((state == ST_IDLE) && in_valid) || b_we;
        bf_en = (state == ST_RUN) && (ph == PH_MUL);
        unique case (state)
            ST_IDLE: a_addr = ld_addr;
            ST_RUN:  a_addr = top;
            ST_OUT:  a_addr = ocnt;
            ST_TAIL: a_addr = ocnt;
        endcase
        a_wd = (state == ST_IDLE) ? {in_im, in_re} : {ya_im, ya_re};
        b_wd = {yb_im, yb_re};
    end

    fft_dpram #(.WIDTH(MW), .AW(AW)) u_mem (
        .clk(clk),
        .a_addr(a_addr), .a_we(a_we), .a_wd(a_wd), .a_rd(a_rd),
        .b_addr(bot),    .b_we(b_we), .b_wd(b_wd), .b_rd(b_rd)
    );

    fft_twiddle #(.KW(KW), .TW_W(TW_W)) u_tw (
        .clk(clk), .k(tw_k), .cos_o(w_c), .sin_o(w_s)
    );

    fft_bfly #(.DW(DATA_W), .TW(TW_W)) u_bf (
        .clk(clk), .en(bf_en),
        .a_re(a_rd[DATA_W-1:0]), .a_im(a_rd[MW-1:DATA_W]),
        .b_re(b_rd[DATA_W-1:0]), .b_im(b_rd[MW-1:DATA_W]),
        .w_c(w_c), .w_s(w_s),
        .ya_re(ya_re), .ya_im(ya_im), .yb_re(yb_re), .yb_im(yb_im)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next-state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_RUN;
            ST_RUN:  if (ph == PH_WR && bix == last_b && stg == log_q - SW'(1))
                         state_nxt = ST_OUT;
            ST_OUT:  if (ocnt == cur_nm1) state_nxt = ST_TAIL;
            ST_TAIL: state_nxt = ST_IDLE;
        endcase
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_q  <= SW'(SMALL_LOG);
            in_cnt <= '0;
            stg    <= '0;
            bix    <= '0;
            ph     <= PH_RD;
            ocnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid)
                        in_cnt <= (in_last || in_cnt == ld_nm1) ? '0 : in_cnt + AW'(1);
                    if (start) begin
                        log_q <= load_log;
                        stg   <= '0;
                        bix   <= '0;
                        ph    <= PH_RD;
                        ocnt  <= '0;
                    end
                end
                ST_RUN: begin
                    unique case (ph)
                        PH_RD:  ph <= PH_MUL;
                        PH_MUL: ph <= PH_WR;
                        PH_WR: begin
                            ph <= PH_RD;
                            if (bix == last_b) begin
                                bix <= '0;
                                stg <= stg + SW'(1);
                            end else begin
                                bix <= bix + AW'(1);
                            end
                        end
                        default: ph <= PH_RD;
                    endcase
                end
                ST_OUT:  ocnt <= ocnt + AW'(1);
                ST_TAIL: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= (state == ST_OUT);
            out_last  <= (state == ST_OUT) && (ocnt == cur_nm1);
        end
    end

    assign busy   = (state != ST_IDLE);
    assign out_re = a_rd[DATA_W-1:0];
    assign out_im = a_rd[MW-1:DATA_W];

    // assertions
    a_r1_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    a_r1_frame_closes: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);
    a_r5_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r6_size_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(log_q));
    a_r7_no_load_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && a_we) |-> b_we);
    a_r2_ports_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |-> (a_addr != bot));
endmodule

// File: tb/sim_fft_iter_core.sv
module sim_fft_iter_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        size_sel = 1'b0, in_valid = 1'b0, in_last = 1'b0, start = 1'b0;
    logic [15:0] in_re = '0, in_im = '0;
    logic        busy, out_valid, out_last;
    logic [15:0] out_re, out_im;

    always #5 clk = ~clk;

    fft_iter_core u0 (
        .clk(clk), .rst_n(rst_n), .size_sel(size_sel),
        .in_valid(in_valid), .in_last(in_last), .in_re(in_re), .in_im(in_im),
        .start(start), .busy(busy), .out_valid(out_valid), .out_last(out_last),
        .out_re(out_re), .out_im(out_im)
    );

    int  n_cmp = 0, n_bad = 0;
    int  xr [1024];
    int  xi [1024];
    real TOL = 5.0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void clear_in();
        for (int i = 0; i < 1024; i++) begin xr[i] = 0; xi[i] = 0; end
    endfunction

    task automatic load_frame(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_re    = 16'(xr[i]);
            in_im    = 16'(xi[i]);
            in_last  = (i == n - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic dft(input int n, input int k, output real er, output real ei);
        real ang;
        er = 0.0; ei = 0.0;
        for (int m = 0; m < n; m++) begin
            ang = -6.283185307179586 * real'((k * m) % n) / real'(n);
            er += real'(xr[m]) * $cos(ang) - real'(xi[m]) * $sin(ang);
            ei += real'(xr[m]) * $sin(ang) + real'(xi[m]) * $cos(ang);
        end
        er = er / real'(n);
        ei = ei / real'(n);
    endtask

    task automatic run_check(input int n, input int lg, input bit disturb, input string tag);
        int  edges;
        real er, ei, d;
        int  ar, ai;
        start = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R5", {tag, " busy after start"}, int'(busy), 1);
        while (!out_valid && edges < 40000) begin
            if (disturb && edges == 60) begin
                // R6 R7: stray start and input sample during the run
                start = 1'b1; in_valid = 1'b1; in_last = 1'b1;
                in_re = 16'sd12345; in_im = -16'sd321;
            end else begin
                start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        chk(edges == 3 * (n / 2) * lg + 2, "R4", {tag, " latency"}, edges, 3 * (n / 2) * lg + 2);
        for (int k = 0; k < n; k++) begin
            dft(n, k, er, ei);
            ar = int'($signed(out_re));
            ai = int'($signed(out_im));
            d  = real'(ar) - er; if (d < 0.0) d = -d;
            chk(d <= TOL, disturb ? "R2/R7" : "R2", $sformatf("%s bin %0d re", tag, k), ar, $rtoi(er));
            d  = real'(ai) - ei; if (d < 0.0) d = -d;
            chk(d <= TOL, disturb ? "R2/R7" : "R2", $sformatf("%s bin %0d im", tag, k), ai, $rtoi(ei));
            if (k == 0 || k == n - 1) begin
                chk(out_valid == 1'b1, "R1", $sformatf("%s valid at %0d", tag, k), int'(out_valid), 1);
                chk(out_last == (k == n - 1), "R1", $sformatf("%s last at %0d", tag, k),
                    int'(out_last), int'(k == n - 1));
                chk(busy == 1'b1, "R5", $sformatf("%s busy at %0d", tag, k), int'(busy), 1);
            end else if (!out_valid || out_last) begin
                chk(1'b0, "R1", $sformatf("%s frame gap/early last at %0d", tag, k),
                    int'(out_valid) * 2 + int'(out_last), 2);
            end
            if (k < n - 1) @(negedge clk);
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", {tag, " valid after frame"}, int'(out_valid), 0);
        chk(busy == 1'b0, disturb ? "R6" : "R5", {tag, " busy after frame"}, int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0, disturb ? "R6" : "R5",
            {tag, " no second frame"}, int'(out_valid) + int'(busy), 0);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8", "busy in reset", int'(busy), 0);
        chk(out_valid == 1'b0, "R8", "valid in reset", int'(out_valid), 0);
        chk(out_last == 1'b0, "R8", "last in reset", int'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0, "R8", "after reset", int'(busy) + int'(out_valid), 0);

        // N=32 impulse at origin
        size_sel = 1'b0;
        clear_in(); xr[0] = 8000;
        load_frame(32);
        run_check(32, 5, 1'b0, "n32 impulse");

        // R3: short frame ended by in_last, then a full frame from x[0]
        clear_in();
        for (int i = 0; i < 7; i++) xr[i] = 9000 + i;
        load_frame(7);
        clear_in(); xr[3] = 16000; xi[3] = -8000;
        load_frame(32);
        run_check(32, 5, 1'b0, "R3 shifted impulse");

        // DC
        clear_in();
        for (int i = 0; i < 32; i++) begin xr[i] = 15000; xi[i] = -9000; end
        load_frame(32);
        run_check(32, 5, 1'b0, "n32 dc");

        // tone at bin 5 with stray start and sample during the run
        clear_in();
        for (int i = 0; i < 32; i++) begin
            xr[i] = $rtoi($floor(15000.0 * $cos(6.283185307179586 * 5.0 * i / 32.0) + 0.5));
            xi[i] = $rtoi($floor(15000.0 * $sin(6.283185307179586 * 5.0 * i / 32.0) + 0.5));
        end
        load_frame(32);
        run_check(32, 5, 1'b1, "n32 tone disturbed");

        // N=1024 tone at bin 100
        size_sel = 1'b1;
        clear_in();
        for (int i = 0; i < 1024; i++) begin
            xr[i] = $rtoi($floor(12000.0 * $cos(6.283185307179586 * 100.0 * i / 1024.0) + 0.5));
            xi[i] = $rtoi($floor(12000.0 * $sin(6.283185307179586 * 100.0 * i / 1024.0) + 0.5));
        end
        load_frame(1024);
        run_check(1024, 10, 1'b0, "n1024 tone");

        // N=1024 broadband pattern
        clear_in();
        for (int i = 0; i < 1024; i++) begin
            xr[i] = ((i * 37) % 200 - 100) * 50;
            xi[i] = ((i * 53 + 11) % 160 - 80) * 40;
        end
        load_frame(1024);
        run_check(1024, 10, 1'b0, "n1024 broadband");

        // back to N=32 (R1 size switch)
        size_sel = 1'b0;
        clear_in(); xr[31] = -16000; xi[31] = 4000;
        load_frame(32);
        run_check(32, 5, 1'b0, "R1 n32 after n1024");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule